// File: doc/BRIEF.md
# Power-Up Initialization and Mode Sequencer

This block covers the power-on initialization phase of a configurable logic device. A power-on reset starts the sequence. The block then waits for a slow internal timer tick, which is nominally 1 MHz. On the first tick after reset is released, it captures the three configuration-mode pins. It then times a delay with a wrapping counter that is 14 bits wide by default. For the whole of that delay, it keeps the user I/O drivers in high impedance, asks for weak pull-ups on the user pins, and blocks power-down.

The captured mode code controls two things. It sets the direction of the configuration clock. It also sets the length of the delay. A master mode stretches the delay to four full counter wraps, so that any slave devices driven from this one have time to finish their own start-up. Every other mode, including the reserved codes, ends after a single wrap. When the delay runs out, the block gives a one-clock done pulse and raises a completion level that holds until the next reset.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_i` is high and right after it falls, the outputs read as follows: `io_tristate_o`=1, `io_pullup_o`=1, `pwrdn_block_o`=1, `init_done_o`=0, `init_complete_o`=0, `mode_error_o`=0, `cclk_out_o`=0 and `mode_o`=7.
- R2: Until `init_complete_o` rises, `io_tristate_o`, `io_pullup_o` and `pwrdn_block_o` all read 1. After it rises, all three read 0.
- R3: `pwrdn_o` equals `pwrdn_req_i` when `init_complete_o` is 1. Otherwise it is 0, so a power-down request made during initialization has no effect.
- R4: The pins `mode_pins_i` = {M0,M1,M2} are captured on the first clock edge after reset release at which `tick_i` is 1. Later changes on the pins do not affect `mode_o`, `mode_error_o`, `cclk_out_o` or the delay length until the next reset.
- R5: The captured code is decoded onto `mode_o` as follows. Code 000 gives 0 (master serial). Code 001 gives 1 (master byte, ascending). Code 011 gives 2 (master byte, descending). Code 100 gives 3 (peripheral byte). Code 110 gives 4 (slave serial). The codes 010, 101 and 111 are reserved and give 7.
- R6: `cclk_out_o` is 1 (configuration clock driven) for mode values 0 to 3. It is 0 (clock is an input) for slave mode, for reserved codes, and before the pins are captured.
- R7: In non-master and reserved modes, initialization completes at the 2^CNT_W-th tick that follows the capture tick.
- R8: In the three master modes, initialization completes at the 4·2^CNT_W-th tick that follows the capture tick.
- R9: `init_done_o` is high for exactly one clock. That clock is the one that follows the edge of the final tick, and it is the same clock in which `init_complete_o` first reads 1.
- R10: Once set, `init_complete_o` stays 1 until `por_i` is asserted again. No further done pulse occurs.
- R11: Asserting `por_i` in the middle of a sequence aborts it and clears both counters. A fresh sequence after release takes the full delay again and recaptures the pins.
- R12: `mode_error_o` is 1 after the capture of a reserved code, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous assert |
| tick_i | input | 1 | One-clock enable from the nominal 1 MHz internal timer |
| mode_pins_i | input | 3 | Mode pins {M0,M1,M2} |
| pwrdn_req_i | input | 1 | Power-down request |
| io_tristate_o | output | 1 | Hold user outputs in high impedance |
| io_pullup_o | output | 1 | Request weak pull-ups on user pins |
| pwrdn_block_o | output | 1 | Power-down inhibited |
| pwrdn_o | output | 1 | Power-down granted |
| cclk_out_o | output | 1 | Configuration clock direction, 1 = output |
| mode_o | output | 3 | Decoded configuration mode |
| mode_error_o | output | 1 | Reserved mode code captured |
| init_done_o | output | 1 | One-clock pulse at end of initialization |
| init_complete_o | output | 1 | Level, initialization finished |

## Verification
All registered results change one clock after the edge that samples the tick that causes them. This covers the mode capture, the counter advance, the done pulse and the completion level. `pwrdn_o` is the only output that follows its request input within the same cycle. The bench uses a behavioural model that counts ticks with integers and updates at each rising edge, using the same tick and pin values the design sees. Inputs are changed only just after the falling edge, and every output is compared at that falling edge, so the design and the model are always compared half a cycle after their shared edge.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int CNT_W        = 14,
  parameter int MASTER_WRAPS = 4
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       tick_i,
  input  logic [2:0] mode_pins_i,
  input  logic       pwrdn_req_i,
  output logic       io_tristate_o,
  output logic       io_pullup_o,
  output logic       pwrdn_block_o,
  output logic       pwrdn_o,
  output logic       cclk_out_o,
  output logic [2:0] mode_o,
  output logic       mode_error_o,
  output logic       init_done_o,
  output logic       init_complete_o
);

  localparam int PASS_W = (MASTER_WRAPS > 1) ? $clog2(MASTER_WRAPS) : 1;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(MASTER_WRAPS - 1);
  localparam logic [2:0] MODE_NONE = 3'd7;

  logic              captured_q, complete_q, done_q, err_q, master_q, cclk_q;
  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PASS_W-1:0] pass_q;

  logic [2:0] dec_mode;
  logic       dec_master, dec_cclk, dec_err;

  always_comb begin
    dec_mode   = MODE_NONE;
    dec_master = 1'b0;
    dec_cclk   = 1'b0;
    dec_err    = 1'b0;
    case (mode_pins_i)
      3'b000: begin dec_mode = 3'd0; dec_master = 1'b1; dec_cclk = 1'b1; end
      3'b001: begin dec_mode = 3'd1; dec_master = 1'b1; dec_cclk = 1'b1; end
      3'b011: begin dec_mode = 3'd2; dec_master = 1'b1; dec_cclk = 1'b1; end
      3'b100: begin dec_mode = 3'd3; dec_cclk = 1'b1; end
      3'b110: begin dec_mode = 3'd4; end
      default: dec_err = 1'b1;
    endcase
  end

  wire running   = captured_q & ~complete_q;
  wire last_wrap = master_q ? (pass_q == LAST_PASS) : 1'b1;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      captured_q <= 1'b0;
      complete_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      master_q   <= 1'b0;
      cclk_q     <= 1'b0;
      mode_q     <= MODE_NONE;
      cnt_q      <= '0;
      pass_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!captured_q && tick_i) begin
        captured_q <= 1'b1;
        mode_q     <= dec_mode;
        master_q   <= dec_master;
        cclk_q     <= dec_cclk;
        err_q      <= dec_err;
      end else if (running && tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) begin
          if (last_wrap) begin
            complete_q <= 1'b1;
            done_q     <= 1'b1;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end
      end
    end
  end

  assign io_tristate_o   = ~complete_q;
  assign io_pullup_o     = ~complete_q;
  assign pwrdn_block_o   = ~complete_q;
  assign pwrdn_o         = pwrdn_req_i & complete_q;
  assign cclk_out_o      = cclk_q;
  assign mode_o          = mode_q;
  assign mode_error_o    = err_q;
  assign init_done_o     = done_q;
  assign init_complete_o = complete_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (por_i)
    init_done_o |=> !init_done_o);
  a_r9_done_after_tick: assert property (@(posedge clk) disable iff (por_i)
    init_done_o |-> $past(tick_i));
  a_r10_complete_sticky: assert property (@(posedge clk) disable iff (por_i)
    init_complete_o |=> init_complete_o);
  a_r4_mode_held: assert property (@(posedge clk) disable iff (por_i)
    captured_q |=> $stable(mode_q) && $stable(master_q) && $stable(cclk_q));
  a_r7_single_pass: assert property (@(posedge clk) disable iff (por_i)
    !master_q |-> pass_q == '0);
  a_r6_cclk_needs_capture: assert property (@(posedge clk) disable iff (por_i)
    cclk_out_o |-> captured_q && !mode_error_o);
  a_r12_err_reserved: assert property (@(posedge clk) disable iff (por_i)
    mode_error_o |-> mode_o == MODE_NONE);

endmodule

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;
  localparam int W = 4;

  logic clk = 1'b0;
  logic por_i = 1'b1, tick_i = 1'b0, pwrdn_req_i = 1'b0;
  logic [2:0] mode_pins_i = 3'b000;
  logic io_tristate_o, io_pullup_o, pwrdn_block_o, pwrdn_o, cclk_out_o;
  logic [2:0] mode_o;
  logic mode_error_o, init_done_o, init_complete_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  pwrup_seq #(.CNT_W(W), .MASTER_WRAPS(4)) dut (
    .clk, .por_i, .tick_i, .mode_pins_i, .pwrdn_req_i,
    .io_tristate_o, .io_pullup_o, .pwrdn_block_o, .pwrdn_o, .cclk_out_o,
    .mode_o, .mode_error_o, .init_done_o, .init_complete_o);

  always #4 clk = ~clk;

  // behavioural reference
  bit m_cap, m_complete, m_done;
  int m_ticks;
  logic [2:0] m_pins;

  function automatic int exp_mode(input logic [2:0] p);
    case (p)
      3'b000: return 0; 3'b001: return 1; 3'b011: return 2;
      3'b100: return 3; 3'b110: return 4; default: return 7;
    endcase
  endfunction

  function automatic int need_ticks(input logic [2:0] p);
    int m = exp_mode(p);
    return (m <= 2) ? 4 * (1 << W) : (1 << W);
  endfunction

  always @(posedge clk) begin
    m_done = 0;
    if (por_i) begin
      m_cap = 0; m_complete = 0; m_ticks = 0;
    end else if (tick_i) begin
      if (!m_cap) begin
        m_cap = 1; m_pins = mode_pins_i;
      end else if (!m_complete) begin
        m_ticks++;
        if (m_ticks == need_ticks(m_pins)) begin
          m_complete = 1; m_done = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    int em;
    em = m_cap ? exp_mode(m_pins) : 7;
    chk("R2 tristate", io_tristate_o, !m_complete);
    chk("R2 pullup", io_pullup_o, !m_complete);
    chk("R2 pwrdn_block", pwrdn_block_o, !m_complete);
    chk("R3 pwrdn", pwrdn_o, pwrdn_req_i & m_complete);
    chk("R5 mode", mode_o, em);
    chk("R6 cclk", cclk_out_o, (em <= 3) ? 1 : 0);
    chk("R12 mode_error", mode_error_o, (m_cap && em == 7) ? 1 : 0);
    chk("R9 done", init_done_o, m_done);
    chk("R7 R8 R10 complete", init_complete_o, m_complete);
  endtask

  // one cycle: compare at negedge, then drive
  task automatic step(input int pat, input bit scramble);
    @(negedge clk);
    compare();
    case (pat)
      0: tick_i = 1'b1;
      1: tick_i = ($urandom % 3) == 0;
      default: tick_i = $urandom % 2;
    endcase
    pwrdn_req_i = $urandom % 2;
    if (scramble && m_cap) mode_pins_i = 3'($urandom);
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_i = 1'b1; tick_i = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R1 reset tristate", io_tristate_o, 1);
      chk("R1 reset done", init_done_o, 0);
      chk("R1 reset complete", init_complete_o, 0);
      chk("R1 reset mode", mode_o, 7);
      chk("R1 reset cclk", cclk_out_o, 0);
      chk("R1 reset err", mode_error_o, 0);
    end
    por_i = 1'b0;
  endtask

  task automatic run_code(input logic [2:0] code, input int pat);
    int done_seen = 0;
    do_reset();
    mode_pins_i = code;
    for (int i = 0; i < 400 && !m_complete; i++) begin
      step(pat, 1'b1);   // R4: pins scrambled after capture
      if (init_done_o) done_seen++;
    end
    for (int i = 0; i < 6; i++) begin
      step(pat, 1'b1);
      if (init_done_o) done_seen++;
    end
    chk("R9 R10 done pulse count", done_seen, 1);
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) run_code(3'(c), c % 3);
    run_code(3'b001, 0);
    run_code(3'b110, 0);
    // R11: abort mid-sequence, then rerun full delay with a new mode
    do_reset();
    mode_pins_i = 3'b000;
    for (int i = 0; i < 30; i++) step(0, 1'b0);
    chk("R11 mid-sequence not complete", init_complete_o, 0);
    run_code(3'b110, 0);
    do_reset();
    mode_pins_i = 3'b100;
    for (int i = 0; i < 10; i++) step(0, 1'b0);
    run_code(3'b011, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule